// File: doc/BRIEF.md
# Keyed I/O Configuration Port Controller

This block sits on an ISA-style I/O bus and gives firmware a locked window onto a small bank of 8-bit configuration registers. It listens for I/O writes at a base address. A write of the unlock key 0x55 to that address moves the block from its run state into its configuration state. A write of the lock key 0xAA at the same address moves it back.

While the block is unlocked, the base address acts as an index port and base+1 acts as a data port. Firmware writes a register number to the index port, then reads or writes that register through the data port. When the block is locked, both ports are inert. Every decode is gated by the address-enable signal, so accesses made while it is high are never seen.

The base address itself is held in two configuration registers, so firmware can move the port after power-up. A strap input picks the starting base during reset. A parameterised group of device registers sits in the same bank. Bit 0 of each device register drives one logical-device enable output. Locking and unlocking leaves those outputs alone.

Top module: `cfg_port_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to the run state. It clears every dev_en bit and sets the index register to 0x00.
- R2: The base address loaded during reset follows strap_sel as sampled at the last reset edge. Low gives 0x03F0 and high gives 0x0370.
- R3: In the run state, a write of 0x55 to the base address enters the configuration state. Any other value written there in the run state changes nothing, and the index is unaffected.
- R4: In the configuration state, a write of 0xAA to the base address returns the block to the run state.
- R5: In the configuration state, a base-address write of any value other than 0xAA loads the index register. A read of the base address returns the last index written, with io_rdata_oe high.
- R6: In the configuration state, a data-port write (base+1) stores the byte in the register selected by the index. A data-port read returns it. Indices with no register behind them read 0x00 and discard writes.
- R7: In the run state, reads of the base and base+1 keep io_rdata_oe low, and data-port writes leave every register unchanged.
- R8: While aen is high, no read or write is recognised. Keys, index writes and data writes have no effect, and io_rdata_oe stays low.
- R9: Register index 0x26 holds base address bits 7:0 and index 0x27 holds bits 15:8. A new value is used from the next access onward, and the old address stops responding.
- R10: The device register at index 0x30+n drives dev_en[n] from its bit 0. Entering or leaving the configuration state does not change dev_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_sel | input | 1 | Default base select, sampled during reset |
| aen | input | 1 | Address enable; high blocks every decode |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rdata_oe is high |
| io_rdata_oe | output | 1 | Read data drive enable |
| cfg_mode | output | 1 | High in the configuration state |
| dev_en | output | 4 | Logical-device enable bits |

## Verification
The hardest case is a relocation done in two steps. After the low byte of the base changes, the data port has already moved. The high byte must then be written at the new base+1, not at the old one. The stimulus moves the base in two writes, following the port at each step. It then checks that the old address is silent and that the lock key works at the final address. A second reset with the strap high drives the other default base, and both base bytes are read back through the data port.

// File: rtl/cfgp_pkg.sv
// Shared constants and types for the keyed configuration port.
// Assumes 8-bit register indices and a 16-bit I/O base address.
package cfgp_pkg;
    localparam logic [7:0]  KEY_UNLOCK   = 8'h55;
    localparam logic [7:0]  KEY_LOCK     = 8'hAA;
    localparam logic [7:0]  IDX_BASE_LO  = 8'h26;
    localparam logic [7:0]  IDX_BASE_HI  = 8'h27;
    localparam logic [15:0] BASE_STRAP_0 = 16'h03F0;
    localparam logic [15:0] BASE_STRAP_1 = 16'h0370;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } port_state_t;
endpackage

// File: rtl/cfgp_decode.sv
// Address decoder: compares the bus address with the current base and
// base+1. Every hit is gated by aen. It does not look at the lock state.
// Assumes io_wr and io_rd are single-cycle strobes.
module cfgp_decode #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic          aen,
    input  logic [AW-1:0] base_addr,
    output logic          base_wr,
    output logic          base_rd,
    output logic          data_wr,
    output logic          data_rd
);
    logic [AW-1:0] data_addr;
    logic          at_base;
    logic          at_data;

    // Compute the data port address and the two address matches.
    always_comb begin
        data_addr = base_addr + AW'(1);
        at_base   = !aen && (io_addr == base_addr);
        at_data   = !aen && (io_addr == data_addr);
    end

    // Combine the address matches with the bus strobes.
    always_comb begin
        base_wr = at_base && io_wr;
        base_rd = at_base && io_rd;
        data_wr = at_data && io_wr;
        data_rd = at_data && io_rd;
    end
endmodule

// File: rtl/cfgp_keyfsm.sv
// Lock state machine: the unlock key opens the configuration state and the
// lock key closes it. In the configuration state, other base writes are
// passed on as index loads. Assumes base_wr is already gated by aen.
module cfgp_keyfsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_wr,
    input  logic [7:0] wdata,
    output logic       cfg_mode,
    output logic       idx_load
);
    port_state_t state, state_nx;

    // Choose the next state from the key bytes.
    always_comb begin
        state_nx = state;
        if (base_wr) begin
            if (state == ST_RUN && wdata == KEY_UNLOCK)
                state_nx = ST_CFG;
            else if (state == ST_CFG && wdata == KEY_LOCK)
                state_nx = ST_RUN;
        end
    end

    // Register the state; reset returns to run.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Drive the outputs: the state flag and the index load for non-key bytes.
    always_comb begin
        cfg_mode = (state == ST_CFG);
        idx_load = base_wr && (state == ST_CFG) && (wdata != KEY_LOCK);
    end

    // R3: an unlock key written in the run state opens the configuration state
    a_r3_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && base_wr && wdata == KEY_UNLOCK) |=> cfg_mode);
    // R3: any other byte written in the run state leaves the block locked
    a_r3_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && base_wr && wdata != KEY_UNLOCK) |=> !cfg_mode);
    // R4: the lock key returns the block to the run state
    a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && base_wr && wdata == KEY_LOCK) |=> !cfg_mode);
    // R8: the state does not move without a decoded base write
    a_r8_no_spurious_move: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> $stable(cfg_mode));
endmodule

// File: rtl/cfgp_regbank.sv
// Configuration register bank: the index register, the two base bytes and
// NDEV device registers at DEV_IDX0 and up. Bit 0 of each device register
// is an enable output. Reads of indices with no register return zero.
// Assumes data_wr is already gated by aen and by the configuration state.
module cfgp_regbank
    import cfgp_pkg::*;
#(
    parameter int         NDEV     = 4,
    parameter logic [7:0] DEV_IDX0 = 8'h30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_sel,
    input  logic            idx_load,
    input  logic            data_wr,
    input  logic [7:0]      wdata,
    output logic [7:0]      index,
    output logic [15:0]     base_addr,
    output logic [7:0]      rd_val,
    output logic [NDEV-1:0] dev_en
);
    localparam logic [15:0] BASE0 = BASE_STRAP_0;
    localparam logic [15:0] BASE1 = BASE_STRAP_1;

    logic [7:0] base_lo, base_hi;
    logic [7:0] dev_reg [NDEV];
    logic [7:0] dev_rd  [NDEV];
    logic [NDEV-1:0] dev_hit;

    // Hold the index register; it is loaded by non-key base writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        index <= 8'h00;
        else if (idx_load) index <= wdata;
    end

    // Hold the base bytes; the strap picks the value loaded during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo <= strap_sel ? BASE1[7:0]  : BASE0[7:0];
            base_hi <= strap_sel ? BASE1[15:8] : BASE0[15:8];
        end else if (data_wr) begin
            if (index == IDX_BASE_LO) base_lo <= wdata;
            if (index == IDX_BASE_HI) base_hi <= wdata;
        end
    end

    assign base_addr = {base_hi, base_lo};

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        localparam logic [7:0] MY_IDX = DEV_IDX0 + 8'(g);

        // Decode whether the current index selects this device register.
        always_comb dev_hit[g] = (index == MY_IDX);

        // Hold one device register, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                   dev_reg[g] <= 8'h00;
            else if (data_wr && dev_hit[g]) dev_reg[g] <= wdata;
        end

        // Mask this register's read value onto the shared bus.
        always_comb dev_rd[g] = dev_hit[g] ? dev_reg[g] : 8'h00;

        // Drive this device's enable from bit 0.
        always_comb dev_en[g] = dev_reg[g][0];
    end

    // Select the read value for the current index; zero when no register is there.
    always_comb begin
        rd_val = 8'h00;
        if (index == IDX_BASE_LO) rd_val = base_lo;
        if (index == IDX_BASE_HI) rd_val = base_hi;
        for (int i = 0; i < NDEV; i++) rd_val = rd_val | dev_rd[i];
    end

    // Track the first cycle after reset, so $past never sees a pre-reset value.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10: the device enables only move on a data-port write
    a_r10_enables_hold: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !data_wr |=> $stable(dev_en));
    // R9: a data write at the low-byte index lands in base bits 7:0
    a_r9_base_lo_update: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index == IDX_BASE_LO) |=> (base_addr[7:0] == $past(wdata)));
    // R9: a data write at the high-byte index lands in base bits 15:8
    a_r9_base_hi_update: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index == IDX_BASE_HI) |=> (base_addr[15:8] == $past(wdata)));
    // R5: the index changes only through an index load
    a_r5_index_hold: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !idx_load |=> $stable(index));
endmodule

// File: rtl/cfg_port_ctrl.sv
// Keyed I/O configuration port. It joins the address decoder, the lock
// state machine and the register bank, and drives the read bus. Reads are
// combinational within the strobe cycle. Assumes AW is 16.
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int         AW       = 16,
    parameter int         NDEV     = 4,
    parameter logic [7:0] DEV_IDX0 = 8'h30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_sel,
    input  logic            aen,
    input  logic [AW-1:0]   io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    output logic            io_rdata_oe,
    output logic            cfg_mode,
    output logic [NDEV-1:0] dev_en
);
    logic          base_wr, base_rd, data_wr, data_rd;
    logic          idx_load, reg_wr;
    logic [7:0]    index, rd_val;
    logic [15:0]   base16;
    logic [AW-1:0] base_addr;

    assign base_addr = AW'(base16);

    cfgp_decode #(.AW(AW)) u_dec (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .aen      (aen),
        .base_addr(base_addr),
        .base_wr  (base_wr),
        .base_rd  (base_rd),
        .data_wr  (data_wr),
        .data_rd  (data_rd)
    );

    cfgp_keyfsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_wr (base_wr),
        .wdata   (io_wdata),
        .cfg_mode(cfg_mode),
        .idx_load(idx_load)
    );

    // Let data-port writes reach the bank only while unlocked.
    always_comb reg_wr = data_wr && cfg_mode;

    cfgp_regbank #(.NDEV(NDEV), .DEV_IDX0(DEV_IDX0)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_sel(strap_sel),
        .idx_load (idx_load),
        .data_wr  (reg_wr),
        .wdata    (io_wdata),
        .index    (index),
        .base_addr(base16),
        .rd_val   (rd_val),
        .dev_en   (dev_en)
    );

    // Drive the read bus: the index at the base, the selected register at base+1.
    always_comb begin
        io_rdata_oe = cfg_mode && (base_rd || data_rd);
        io_rdata    = 8'h00;
        if (cfg_mode && base_rd)      io_rdata = index;
        else if (cfg_mode && data_rd) io_rdata = rd_val;
    end

    // R7: nothing is driven onto the bus while locked
    a_r7_quiet_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> !io_rdata_oe);
    // R8: nothing is driven while the address enable is high
    a_r8_aen_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> !io_rdata_oe);
    // R8: a write seen while aen is high leaves the lock state alone
    a_r8_aen_blocks_key: assert property (@(posedge clk) disable iff (!rst_n)
        (aen && io_wr) |=> $stable(cfg_mode));
endmodule

// File: tb/cfg_port_ctrl_test.sv
module cfg_port_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_sel = 1'b0;
    logic        aen = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        cfg_mode;
    logic [3:0]  dev_en;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    cfg_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .aen(aen),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .cfg_mode(cfg_mode), .dev_en(dev_en)
    );

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_sel = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic en_hi = 1'b0);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; aen = en_hi;
        @(negedge clk);
        io_wr = 1'b0; aen = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic oe,
                           input logic en_hi = 1'b0);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; aen = en_hi;
        #4;
        d = io_rdata; oe = io_rdata_oe;
        io_rd = 1'b0; aen = 1'b0;
    endtask

    task automatic read_reg(input logic [15:0] base, input logic [7:0] idx,
                            output logic [7:0] d, output logic oe);
        io_write(base, idx);
        io_read(base + 16'd1, d, oe);
    endtask

    task automatic t_reset_state();
        logic [7:0] d; logic oe;
        do_reset(1'b0);
        check("R1 cfg_mode after reset", int'(cfg_mode), 0);
        check("R1 dev_en after reset", int'(dev_en), 0);
        io_read(16'h03F0, d, oe);
        check("R7 base read oe while locked", int'(oe), 0);
    endtask

    task automatic t_key_and_index();
        logic [7:0] d; logic oe;
        io_write(16'h03F0, 8'h12);
        check("R3 non-key byte in run", int'(cfg_mode), 0);
        io_write(16'h03F0, 8'h55);
        check("R3 unlock key", int'(cfg_mode), 1);
        io_read(16'h03F0, d, oe);
        check("R3 index untouched by run write (oe)", int'(oe), 1);
        check("R1 R3 index reset value", int'(d), 8'h00);
        io_write(16'h03F0, 8'h31);
        io_read(16'h03F0, d, oe);
        check("R5 index readback", int'(d), 8'h31);
        check("R2 strap low base 0x03F0 responds", int'(cfg_mode), 1);
    endtask

    task automatic t_data_rw();
        logic [7:0] d; logic oe;
        io_write(16'h03F0, 8'h30);
        io_write(16'h03F1, 8'h01);
        check("R10 dev_en[0] set", int'(dev_en), 4'b0001);
        io_read(16'h03F1, d, oe);
        check("R6 data readback idx 0x30", int'(d), 8'h01);
        io_write(16'h03F0, 8'h31);
        io_write(16'h03F1, 8'hA5);
        check("R10 dev_en[1] set", int'(dev_en), 4'b0011);
        io_read(16'h03F1, d, oe);
        check("R6 data readback idx 0x31", int'(d), 8'hA5);
        read_reg(16'h03F0, 8'h10, d, oe);
        io_write(16'h03F1, 8'h77);
        io_read(16'h03F1, d, oe);
        check("R6 unimplemented index reads zero", int'(d), 8'h00);
        check("R6 unimplemented read oe", int'(oe), 1);
    endtask

    task automatic t_lock_inert();
        logic [7:0] d; logic oe;
        io_write(16'h03F0, 8'h30);
        io_write(16'h03F0, 8'hAA);
        check("R4 lock key", int'(cfg_mode), 0);
        check("R10 enables kept on lock", int'(dev_en), 4'b0011);
        io_write(16'h03F1, 8'h00);
        check("R7 data write while locked", int'(dev_en), 4'b0011);
        io_read(16'h03F1, d, oe);
        check("R7 data read oe while locked", int'(oe), 0);
        io_write(16'h03F0, 8'h55);
        check("R10 enables kept on unlock", int'(dev_en), 4'b0011);
        io_read(16'h03F1, d, oe);
        check("R7 register kept after locked write", int'(d), 8'h01);
    endtask

    task automatic t_aen();
        logic [7:0] d; logic oe;
        io_read(16'h03F0, d, oe, 1'b1);
        check("R8 read with aen high", int'(oe), 0);
        io_write(16'h03F0, 8'h44, 1'b1);
        io_read(16'h03F0, d, oe);
        check("R8 index write with aen high", int'(d), 8'h30);
        io_write(16'h03F1, 8'h00, 1'b1);
        check("R8 data write with aen high", int'(dev_en), 4'b0011);
        io_write(16'h03F0, 8'hAA, 1'b1);
        check("R8 lock key with aen high", int'(cfg_mode), 1);
        io_write(16'h03F0, 8'hAA);
        io_write(16'h03F0, 8'h55, 1'b1);
        check("R8 unlock key with aen high", int'(cfg_mode), 0);
        io_write(16'h03F0, 8'h55);
    endtask

    task automatic t_relocate();
        logic [7:0] d; logic oe;
        io_write(16'h03F0, 8'h26);
        io_write(16'h03F1, 8'h50);
        io_read(16'h0350, d, oe);
        check("R9 low byte moves index port", int'(d), 8'h26);
        io_write(16'h0350, 8'h27);
        io_write(16'h0351, 8'h02);
        io_read(16'h0250, d, oe);
        check("R9 high byte moves index port", int'(d), 8'h27);
        io_read(16'h0251, d, oe);
        check("R9 high byte readback", int'(d), 8'h02);
        io_read(16'h03F0, d, oe);
        check("R9 old base silent", int'(oe), 0);
        io_write(16'h0250, 8'hAA);
        check("R9 lock at new base", int'(cfg_mode), 0);
        io_write(16'h03F0, 8'h55);
        check("R9 old base ignores key", int'(cfg_mode), 0);
        io_write(16'h0250, 8'h55);
        check("R9 unlock at new base", int'(cfg_mode), 1);
    endtask

    task automatic t_strap_high();
        logic [7:0] d; logic oe;
        do_reset(1'b1);
        check("R1 dev_en cleared by second reset", int'(dev_en), 0);
        io_write(16'h03F0, 8'h55);
        check("R2 strap high ignores 0x03F0", int'(cfg_mode), 0);
        io_write(16'h0370, 8'h55);
        check("R2 strap high unlock at 0x0370", int'(cfg_mode), 1);
        read_reg(16'h0370, 8'h26, d, oe);
        check("R2 base low byte", int'(d), 8'h70);
        read_reg(16'h0370, 8'h27, d, oe);
        check("R2 base high byte", int'(d), 8'h03);
    endtask

    initial begin
        #(20 * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset_state();
        t_key_and_index();
        t_data_rw();
        t_lock_inert();
        t_aen();
        t_relocate();
        t_strap_high();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule